// File: doc/BRIEF.md
# Multi-Slot Card Interface Register Controller

This block is the register and interrupt core of a five-slot smart card interface. A host reaches it over a byte-wide register bus with a 2-bit register select. A bank register picks what the other two register addresses reach. One choice is a general bank, which holds an identification code and a summary of pending events. The other five choices are per-slot banks, each with a status byte whose event flags clear when read and a control byte that requests card activation.

The block watches a card-present input per slot and drives an activation output per slot. Its active-low attention line stays low while any slot has an unread event. A standby input, active low, freezes the block and stops all bus acknowledgement. While in standby, the attention line reports a change in card presence without latching it. When standby is released, the block reinitialises itself. Card power sequencing, the serial data path and the converter lie outside the block. The per-slot present input and activation output stand in for them.

Top module: `card_slot_regctl`

## Requirements
- R1: Register select 0 is the bank register. Writing 0 selects the general bank and writing 1 to 5 selects slot 1 to slot 5. The low three written bits are stored and read back at select 0. With 6 or 7 stored, selects 1 and 2 read 00h. Select 3 always reads 00h.
- R2: With the general bank selected, a read at select 1 returns the identification code C1h.
- R3: With the general bank selected, a read at select 2 returns one pending bit per slot, with bit k-1 for slot k and the upper bits 0. It reads 1Fh after reset and clears no flag.
- R4: Each slot status byte has a supply-event flag at bit 3. The flag is set by reset and by standby release, and it is cleared by a read at select 1 while that slot is selected.
- R5: Status bit 0 is the sampled card presence. Bit 1 is set whenever presence toggles and is cleared by the status read. After an insertion, two reads return 03h and then 01h.
- R6: A slot is pending when its bit 3 or bit 1 is set. One cycle after the flags settle, attn_n is low if any slot is pending and high if none is. It is high during reset.
- R7: A write at select 1 with a slot selected loads the control byte, keeping bit 0 start, bit 1 warm reset, bit 2 high-voltage select and bit 6 I/O enable. The other bits read as 0. A read at select 2 with a slot selected returns the control byte.
- R8: slot_act[k] is the start bit of slot k ANDed with its sampled presence. A card removal clears that slot's start bit.
- R9: While standby_n is low, bus_ack stays 0 and bus writes have no effect.
- R10: After standby_n rises, attn_n is high for two cycles and then low. Every register returns to its reset value: bank 00h, control 00h, all supply flags set.
- R11: During standby, attn_n is low exactly when a card-present input differs from the last sampled presence. No change flag is latched, so after release that slot reads only presence and supply (09h).
- R12: Each bus read or write accepted outside standby raises bus_ack in the following cycle, with bus_rdata valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_n | input | 1 | Low holds the block in standby |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| card_present | input | 5 | Card presence per slot |
| slot_act | output | 5 | Activation request per slot |
| attn_n | output | 1 | Active-low attention line |

## Verification
The hardest situation to reach from the ports is the standby window. It needs a presence change that must steer the attention line without leaving a flag behind, followed by a release whose two-cycle high pulse must be caught at exact cycles. Directed steps insert a card after standby entry, sample attn_n on each of the three cycles after release, and read that slot's status to show that only presence and supply remain. Random phases then toggle cards, switch banks (including the unused codes 6 and 7) and mix status reads with control writes. They also hit insertion or removal while a start bit is set, against a bench model of every flag.

// File: rtl/card_regs_pkg.sv
package card_regs_pkg;

    localparam logic [7:0] ID_CODE = 8'hC1;

    typedef enum logic [1:0] {
        RA_BANK  = 2'd0,
        RA_STAT  = 2'd1,
        RA_AUX   = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    // status byte bit positions
    localparam int SB_CARD = 0;
    localparam int SB_FLIP = 1;
    localparam int SB_PWR  = 3;

    // control byte bit positions
    localparam int CB_GO   = 0;
    localparam int CB_WRST = 1;
    localparam int CB_HIV  = 2;
    localparam int CB_IOON = 6;

    typedef struct packed {
        logic io_on;
        logic hi_volt;
        logic wrst;
        logic go;
    } slot_ctrl_t;

    typedef struct packed {
        logic pwr;
        logic flip;
        logic card;
    } slot_flags_t;

    function automatic logic [7:0] ctrl_to_byte(slot_ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CB_GO]   = c.go;
        b[CB_WRST] = c.wrst;
        b[CB_HIV]  = c.hi_volt;
        b[CB_IOON] = c.io_on;
        return b;
    endfunction

    function automatic slot_ctrl_t byte_to_ctrl(logic [7:0] b);
        slot_ctrl_t c;
        c.go      = b[CB_GO];
        c.wrst    = b[CB_WRST];
        c.hi_volt = b[CB_HIV];
        c.io_on   = b[CB_IOON];
        return c;
    endfunction

    function automatic logic [7:0] flags_to_byte(slot_flags_t f);
        logic [7:0] b;
        b = '0;
        b[SB_CARD] = f.card;
        b[SB_FLIP] = f.flip;
        b[SB_PWR]  = f.pwr;
        return b;
    endfunction

endpackage

// File: rtl/card_slot_unit.sv
module card_slot_unit
    import card_regs_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       run,
    input  logic       present_in,
    input  logic       rd_status,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    output logic [7:0] status_byte,
    output logic [7:0] ctrl_byte,
    output logic       pending,
    output logic       card_seen,
    output logic       act
);

    slot_flags_t fl;
    slot_ctrl_t  ct;

    always_ff @(posedge clk) begin
        if (clr) begin
            fl.card <= present_in;
            fl.flip <= 1'b0;
            fl.pwr  <= 1'b1;
            ct      <= '0;
        end else if (run) begin
            fl.card <= present_in;
            if (present_in != fl.card)
                fl.flip <= 1'b1;
            else if (rd_status)
                fl.flip <= 1'b0;
            if (rd_status)
                fl.pwr <= 1'b0;
            if (wr_ctrl)
                ct <= byte_to_ctrl(wdata);
            if (fl.card && !present_in)
                ct.go <= 1'b0;
        end
    end

    assign status_byte = flags_to_byte(fl);
    assign ctrl_byte   = ctrl_to_byte(ct);
    assign pending     = fl.pwr | fl.flip;
    assign card_seen   = fl.card;
    assign act         = ct.go & fl.card;

    // R4: a status read leaves the supply flag clear
    a_r4_pwr_clears: assert property (@(posedge clk) disable iff (clr)
        (run && rd_status) |=> !status_byte[SB_PWR]);

    // R5: a presence toggle always raises the change flag
    a_r5_toggle_flags: assert property (@(posedge clk) disable iff (clr)
        (run && (present_in != card_seen)) |=> status_byte[SB_FLIP]);

    // R8: removal drops the activation request
    a_r8_removal_stops: assert property (@(posedge clk) disable iff (clr)
        (run && card_seen && !present_in) |=> !act);

endmodule

// File: rtl/card_bus_front.sv
module card_bus_front
    import card_regs_pkg::*;
#(
    parameter int          NSLOT = 5,
    parameter logic [7:0]  ID    = ID_CODE,
    parameter int          SELW  = $clog2(NSLOT + 1)
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  active,
    input  logic                  we,
    input  logic                  re,
    input  logic [1:0]            addr,
    input  logic [SELW-1:0]       bank_wdata,
    input  logic [NSLOT-1:0][7:0] stat_v,
    input  logic [NSLOT-1:0][7:0] ctrl_v,
    input  logic [NSLOT-1:0]      pend_v,
    output logic [NSLOT-1:0]      rd_stat,
    output logic [NSLOT-1:0]      wr_ctrl,
    output logic [7:0]            rdata,
    output logic                  ack
);

    logic [SELW-1:0] bank_q;
    logic [SELW-1:0] idx;
    logic            in_slot;
    logic            in_gen;
    logic [7:0]      rd_mux;
    reg_addr_e       ra;

    assign ra      = reg_addr_e'(addr);
    assign in_gen  = (bank_q == '0);
    assign in_slot = !in_gen && (int'(bank_q) <= NSLOT);
    assign idx     = bank_q - SELW'(1);

    always_comb begin
        case (ra)
            RA_BANK: rd_mux = 8'(bank_q);
            RA_STAT: rd_mux = in_gen ? ID : (in_slot ? stat_v[idx] : 8'h00);
            RA_AUX:  rd_mux = in_gen ? 8'(pend_v) : (in_slot ? ctrl_v[idx] : 8'h00);
            default: rd_mux = 8'h00;
        endcase
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_strobe
        assign rd_stat[g] = active & re & (ra == RA_STAT) & (bank_q == SELW'(g + 1));
        assign wr_ctrl[g] = active & we & (ra == RA_STAT) & (bank_q == SELW'(g + 1));
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            bank_q <= '0;
            rdata  <= '0;
            ack    <= 1'b0;
        end else begin
            ack <= active & (we | re);
            if (active && re)
                rdata <= rd_mux;
            if (active && we && (ra == RA_BANK))
                bank_q <= bank_wdata;
        end
    end

    // R1: a bank write is stored as written
    a_r1_bank_store: assert property (@(posedge clk) disable iff (clr)
        (active && we && (ra == RA_BANK)) |=> (bank_q == $past(bank_wdata)));

    // R12: accepted accesses are acknowledged next cycle
    a_r12_ack_follows: assert property (@(posedge clk) disable iff (clr)
        (active && (we || re)) |=> ack);

endmodule

// File: rtl/card_power_ctl.sv
module card_power_ctl #(
    parameter int NSLOT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby_n,
    input  logic [NSLOT-1:0] card_in,
    input  logic [NSLOT-1:0] card_seen,
    input  logic [NSLOT-1:0] pend_v,
    output logic             active,
    output logic             clr,
    output logic             attn_n
);

    logic sb_q;
    logic wake_q;
    logic attn_q;
    logic rising;

    assign rising = standby_n & ~sb_q;
    assign clr    = rst | wake_q;
    assign active = standby_n & sb_q & ~wake_q;
    assign attn_n = attn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_q   <= 1'b1;
            wake_q <= 1'b0;
            attn_q <= 1'b1;
        end else begin
            sb_q   <= standby_n;
            wake_q <= rising;
            if (rising || wake_q)
                attn_q <= 1'b1;
            else if (!standby_n)
                attn_q <= ~|(card_in ^ card_seen);
            else
                attn_q <= ~|pend_v;
        end
    end

    // R6: attention follows the pending vector in normal operation
    a_r6_attn_low: assert property (@(posedge clk) disable iff (rst)
        (active && (pend_v != '0)) |=> !attn_n);
    a_r6_attn_high: assert property (@(posedge clk) disable iff (rst)
        (active && (pend_v == '0)) |=> attn_n);

    // R10: release of standby starts with attention high
    a_r10_wake_high: assert property (@(posedge clk) disable iff (rst)
        (standby_n && !sb_q) |=> attn_n);

    // R11: in standby, no presence change keeps attention high
    a_r11_quiet_standby: assert property (@(posedge clk) disable iff (rst)
        (!standby_n && (card_in == card_seen)) |=> attn_n);

endmodule

// File: rtl/card_slot_regctl.sv
module card_slot_regctl
    import card_regs_pkg::*;
#(
    parameter int         NSLOT = 5,
    parameter logic [7:0] ID    = ID_CODE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby_n,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [1:0]       bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             bus_ack,
    input  logic [NSLOT-1:0] card_present,
    output logic [NSLOT-1:0] slot_act,
    output logic             attn_n
);

    localparam int SELW = $clog2(NSLOT + 1);

    logic                  active;
    logic                  clr;
    logic [NSLOT-1:0]      rd_stat;
    logic [NSLOT-1:0]      wr_ctrl;
    logic [NSLOT-1:0]      pend_v;
    logic [NSLOT-1:0]      seen_v;
    logic [NSLOT-1:0][7:0] stat_v;
    logic [NSLOT-1:0][7:0] ctrl_v;

    card_power_ctl #(.NSLOT(NSLOT)) u_power (
        .clk       (clk),
        .rst       (rst),
        .standby_n (standby_n),
        .card_in   (card_present),
        .card_seen (seen_v),
        .pend_v    (pend_v),
        .active    (active),
        .clr       (clr),
        .attn_n    (attn_n)
    );

    card_bus_front #(.NSLOT(NSLOT), .ID(ID), .SELW(SELW)) u_front (
        .clk        (clk),
        .clr        (clr),
        .active     (active),
        .we         (bus_we),
        .re         (bus_re),
        .addr       (bus_sel),
        .bank_wdata (bus_wdata[SELW-1:0]),
        .stat_v     (stat_v),
        .ctrl_v     (ctrl_v),
        .pend_v     (pend_v),
        .rd_stat    (rd_stat),
        .wr_ctrl    (wr_ctrl),
        .rdata      (bus_rdata),
        .ack        (bus_ack)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        card_slot_unit u_slot (
            .clk         (clk),
            .clr         (clr),
            .run         (active),
            .present_in  (card_present[s]),
            .rd_status   (rd_stat[s]),
            .wr_ctrl     (wr_ctrl[s]),
            .wdata       (bus_wdata),
            .status_byte (stat_v[s]),
            .ctrl_byte   (ctrl_v[s]),
            .pending     (pend_v[s]),
            .card_seen   (seen_v[s]),
            .act         (slot_act[s])
        );
    end

    // R9: standby blocks acknowledgement
    a_r9_no_ack_standby: assert property (@(posedge clk) disable iff (rst)
        !standby_n |=> !bus_ack);

    // R8: only one slot can be written per access
    a_r8_one_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ctrl));

endmodule

// File: tb/test_card_slot_regctl.sv
module test_card_slot_regctl;

    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          standby_n = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [1:0]    bus_sel = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_ack;
    logic [NS-1:0] card_present = '0;
    logic [NS-1:0] slot_act;
    logic          attn_n;

    always #4 clk = ~clk;

    card_slot_regctl i_card_slot_regctl (
        .clk          (clk),
        .rst          (rst),
        .standby_n    (standby_n),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ack      (bus_ack),
        .card_present (card_present),
        .slot_act     (slot_act),
        .attn_n       (attn_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    int                m_sel;
    logic [NS-1:0]     m_supl, m_chg, m_pres;
    logic [NS-1:0][7:0] m_ctrl;

    function automatic logic [7:0] m_stat(int k);
        return {4'b0, m_supl[k], 1'b0, m_chg[k], m_pres[k]};
    endfunction

    function automatic logic [7:0] m_expect(logic [1:0] a);
        bit slot;
        slot = (m_sel != 0) && (m_sel <= NS);
        case (a)
            2'd0: return 8'(m_sel);
            2'd1: return (m_sel == 0) ? 8'hC1 : (slot ? m_stat(m_sel - 1) : 8'h00);
            2'd2: return (m_sel == 0) ? 8'(m_supl | m_chg) : (slot ? m_ctrl[m_sel - 1] : 8'h00);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_init();
        m_sel  = 0;
        m_supl = '1;
        m_chg  = '0;
        m_pres = card_present;
        m_ctrl = '0;
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus(input bit w, input logic [1:0] a, input logic [7:0] d,
                       output logic [7:0] q, output logic k);
        @(negedge clk);
        bus_we = w; bus_re = !w; bus_sel = a; bus_wdata = d;
        @(negedge clk);
        q = bus_rdata; k = bus_ack;
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    task automatic settle();
        logic [NS-1:0] go;
        @(negedge clk);
        for (int i = 0; i < NS; i++) go[i] = m_ctrl[i][0];
        chk("R6 attn_n", 8'(attn_n), 8'(~|(m_supl | m_chg)));
        chk("R8 slot_act", 8'(slot_act), 8'(m_pres & go));
    endtask

    task automatic op_rd(input logic [1:0] a, input string tag, output logic [7:0] q);
        logic [7:0] e;
        logic k;
        e = m_expect(a);
        bus(1'b0, a, 8'h00, q, k);
        chk(tag, q, e);
        chk("R12 read ack", 8'(k), 8'h01);
        if (a == 2'd1 && m_sel != 0 && m_sel <= NS) begin
            m_supl[m_sel - 1] = 1'b0;
            m_chg[m_sel - 1]  = 1'b0;
        end
        settle();
    endtask

    task automatic op_wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] q;
        logic k;
        bus(1'b1, a, d, q, k);
        chk("R12 write ack", 8'(k), 8'h01);
        if (a == 2'd0) m_sel = int'(d[2:0]);
        else if (a == 2'd1 && m_sel != 0 && m_sel <= NS) m_ctrl[m_sel - 1] = d & 8'h47;
        settle();
    endtask

    task automatic op_card(input int i, input logic v);
        @(negedge clk);
        card_present[i] = v;
        @(negedge clk);
        if (m_pres[i] != v) begin
            m_chg[i] = 1'b1;
            if (!v) m_ctrl[i][0] = 1'b0;
        end
        m_pres[i] = v;
        settle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic k;
        void'($urandom(32'h5EED));

        // reset state (R6, R12)
        repeat (3) @(negedge clk);
        chk("R6 attn_n in reset", 8'(attn_n), 8'h01);
        chk("R12 ack in reset", 8'(bus_ack), 8'h00);
        chk("R8 act in reset", 8'(slot_act), 8'h00);
        rst = 1'b0;
        model_init();
        @(negedge clk);
        chk("R6 attn_n after reset", 8'(attn_n), 8'h00);

        // general bank (R1, R2, R3)
        op_rd(2'd0, "R1 bank after reset", q);       chk("R1 lit", q, 8'h00);
        op_rd(2'd1, "R2 id code", q);                chk("R2 lit", q, 8'hC1);
        op_rd(2'd2, "R3 pending after reset", q);    chk("R3 lit", q, 8'h1F);
        op_rd(2'd2, "R3 pending read twice", q);     chk("R3 no clear", q, 8'h1F);

        // supply flags (R4)
        op_wr(2'd0, 8'h01);
        op_rd(2'd0, "R1 bank readback", q);          chk("R1 lit 01", q, 8'h01);
        op_rd(2'd1, "R4 first status", q);           chk("R4 lit 08", q, 8'h08);
        op_rd(2'd1, "R4 second status", q);          chk("R4 lit 00", q, 8'h00);
        op_wr(2'd0, 8'h00);
        op_rd(2'd2, "R3 one slot cleared", q);       chk("R3 lit 1E", q, 8'h1E);
        for (int s = 2; s <= NS; s++) begin
            op_wr(2'd0, 8'(s));
            op_rd(2'd1, "R4 clear slot", q);
        end
        chk("R6 attn_n released", 8'(attn_n), 8'h01);

        // insertion (R5)
        op_card(0, 1'b1);
        chk("R6 attn_n on insert", 8'(attn_n), 8'h00);
        op_wr(2'd0, 8'h01);
        op_rd(2'd1, "R5 insert first", q);           chk("R5 lit 03", q, 8'h03);
        op_rd(2'd1, "R5 insert second", q);          chk("R5 lit 01", q, 8'h01);

        // control byte (R7, R8)
        op_wr(2'd1, 8'h45);
        chk("R8 act on start", 8'(slot_act[0]), 8'h01);
        op_rd(2'd2, "R7 ctrl 45", q);                chk("R7 lit 45", q, 8'h45);
        op_wr(2'd1, 8'h47);
        op_rd(2'd2, "R7 ctrl 47", q);                chk("R7 lit 47", q, 8'h47);
        op_wr(2'd1, 8'h05);
        op_rd(2'd2, "R7 ctrl 05", q);                chk("R7 lit 05", q, 8'h05);
        chk("R8 act with io off", 8'(slot_act[0]), 8'h01);
        op_wr(2'd1, 8'hFF);
        op_rd(2'd2, "R7 ctrl mask", q);              chk("R7 lit mask", q, 8'h47);
        op_wr(2'd0, 8'h02);
        op_wr(2'd1, 8'h41);
        chk("R8 no card no act", 8'(slot_act[1]), 8'h00);
        op_rd(2'd2, "R7 ctrl 41", q);                chk("R7 lit 41", q, 8'h41);
        op_card(0, 1'b0);
        chk("R8 act on removal", 8'(slot_act[0]), 8'h00);
        op_wr(2'd0, 8'h01);
        op_rd(2'd2, "R8 start cleared", q);          chk("R8 lit 46", q, 8'h46);
        op_rd(2'd1, "R8 removal flag", q);           chk("R8 lit 02", q, 8'h02);

        // unused bank codes (R1)
        op_wr(2'd0, 8'h07);
        op_rd(2'd0, "R1 bank 07", q);                chk("R1 lit 07", q, 8'h07);
        op_rd(2'd1, "R1 empty bank status", q);      chk("R1 lit stat", q, 8'h00);
        op_rd(2'd2, "R1 empty bank aux", q);         chk("R1 lit aux", q, 8'h00);
        op_rd(2'd3, "R1 spare select", q);           chk("R1 lit spare", q, 8'h00);

        // standby (R9, R10, R11)
        op_card(0, 1'b1);
        op_wr(2'd0, 8'h01);
        op_rd(2'd1, "R5 reinsert", q);
        @(negedge clk);
        standby_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 quiet standby", 8'(attn_n), 8'h01);
        bus(1'b1, 2'd1, 8'h45, q, k);
        chk("R9 write not acked", 8'(k), 8'h00);
        @(negedge clk);
        chk("R9 write ignored", 8'(slot_act[0]), 8'h00);
        bus(1'b0, 2'd2, 8'h00, q, k);
        chk("R9 read not acked", 8'(k), 8'h00);
        @(negedge clk);
        card_present[2] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 insert in standby", 8'(attn_n), 8'h00);
        standby_n = 1'b1;
        @(negedge clk);
        chk("R10 pulse cycle 1", 8'(attn_n), 8'h01);
        @(negedge clk);
        chk("R10 pulse cycle 2", 8'(attn_n), 8'h01);
        @(negedge clk);
        chk("R10 low after pulse", 8'(attn_n), 8'h00);
        model_init();
        op_rd(2'd0, "R10 bank reset", q);            chk("R10 lit 00", q, 8'h00);
        op_rd(2'd2, "R10 pending reset", q);         chk("R10 lit 1F", q, 8'h1F);
        op_wr(2'd0, 8'h01);
        op_rd(2'd2, "R10 ctrl reset", q);            chk("R10 lit ctrl", q, 8'h00);
        op_wr(2'd0, 8'h03);
        op_rd(2'd1, "R11 no latched change", q);     chk("R11 lit 09", q, 8'h09);

        // random phase against the model (R1, R3, R4, R5, R7, R8)
        for (int n = 0; n < 800; n++) begin
            int r;
            r = $urandom_range(0, 9);
            case (r)
                0, 1: begin
                    int s;
                    s = $urandom_range(0, NS - 1);
                    op_card(s, ~card_present[s]);
                end
                2:    op_wr(2'd0, 8'($urandom_range(0, 7)));
                3, 4: op_rd(2'd1, "R4 R5 random status", q);
                5:    op_wr(2'd1, 8'($urandom_range(0, 255)));
                6:    op_rd(2'd2, "R3 R7 random aux", q);
                7:    op_rd(2'd0, "R1 random bank", q);
                8:    op_rd(2'd3, "R1 random spare", q);
                default: op_wr(2'($urandom_range(2, 3)), 8'($urandom_range(0, 255)));
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule